// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This block is a sequencer for a keypad lock that accepts its secret one bit at a time. The operator places a bit on `key_bit`, gives a one-cycle pulse on `enter`, and does this three times. The lock opens only when every one of the three entered bits equals the matching bit of the stored combination. A wrong bit does not stop the sequence. The machine switches to a parallel mismatch track that accepts the remaining presses in exactly the same way as the correct track. The failure is shown only after the third bit, so an observer cannot tell which position was wrong.

The combination comes from the `code` input. It is captured into an internal register while the synchronous reset is held, and later changes on `code` have no effect. The secret therefore lives in storage, not in the next-state logic. Both final outcomes, open and alarm, stay in place until the next reset.

Top module: `serial_combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the machine returns to its idle state on that edge, from any state, and `unlock` and `error` read 0 in the following cycle. `rst` has priority over every other input.
- R2: An `enter` pulse in the idle state moves to the first compare. In every compare, `key_bit` is sampled in the cycle after the `enter` pulse that led into it. Its value during the pulse cycle is not used.
- R3: When the three entered bits equal the combination, `unlock` rises in the cycle after the third compare and `error` stays 0.
- R4: When any entered bit differs from the combination, `error` rises in the cycle after the third compare and `unlock` stays 0. `error` stays 0 after the first and second entries, whichever position was wrong.
- R5: With `enter` low, every waiting state (idle, between entries, on either track) holds its position for any number of cycles.
- R6: After the machine reaches open or alarm, it holds that outcome until reset. Further `enter` pulses and `key_bit` values have no effect.
- R7: The combination is loaded from `code` only while `rst` is high. Changes on `code` outside reset have no effect on the outcome.
- R8: Bit order: the first entry is compared with `code[0]`, the second with `code[1]`, and the third with `code[2]`.
- R9: `unlock` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also loads the combination |
| enter | input | 1 | One-cycle pulse that submits the bit on `key_bit` |
| key_bit | input | 1 | Entered combination bit |
| code | input | 3 | Combination, captured while `rst` is high |
| unlock | output | 1 | High while the lock is open |
| error | output | 1 | High after a wrong three-bit entry |

## Verification
The embedded properties check on every cycle that the two outcomes exclude each other, that each outcome persists until reset, that reset clears both, that the stored combination stays unchanged outside reset, that waiting states do not move without `enter`, and that an outcome appears only after the final compare. Only the bench scenarios can show that the decision is right. They cover all eight combinations against all eight entered sequences, bit order, silence after early mismatches, sampling of `key_bit` one cycle after the pulse, and immunity to changes on `code`.

// File: rtl/serial_combo_lock.sv
module serial_combo_lock #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic              key_bit,
  input  logic [CODE_W-1:0] code,
  output logic              unlock,
  output logic              error
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMP0, S_WAIT0, S_CMP1, S_WAIT1, S_CMP2, S_OPEN,
    S_BWAIT0, S_BCMP1, S_BWAIT1, S_BCMP2, S_ALARM
  } state_t;

  state_t            state, nxt;
  logic [CODE_W-1:0] combo_q;

  always_ff @(posedge clk) begin
    if (rst) combo_q <= code;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (enter) nxt = S_CMP0;
      S_CMP0:   nxt = (key_bit == combo_q[0]) ? S_WAIT0 : S_BWAIT0;
      S_WAIT0:  if (enter) nxt = S_CMP1;
      S_CMP1:   nxt = (key_bit == combo_q[1]) ? S_WAIT1 : S_BWAIT1;
      S_WAIT1:  if (enter) nxt = S_CMP2;
      S_CMP2:   nxt = (key_bit == combo_q[2]) ? S_OPEN : S_ALARM;
      S_BWAIT0: if (enter) nxt = S_BCMP1;
      S_BCMP1:  nxt = S_BWAIT1;
      S_BWAIT1: if (enter) nxt = S_BCMP2;
      S_BCMP2:  nxt = S_ALARM;
      S_OPEN:   nxt = S_OPEN;
      S_ALARM:  nxt = S_ALARM;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  assign unlock = (state == S_OPEN);
  assign error  = (state == S_ALARM);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(unlock && error));

  p_open_hold_r6: assert property (@(posedge clk) disable iff (rst)
    unlock |=> unlock);

  p_alarm_hold_r6: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!unlock && !error));

  p_combo_stable_r7: assert property (@(posedge clk)
    !rst |=> $stable(combo_q));

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((state == S_IDLE || state == S_WAIT0 || state == S_WAIT1 ||
      state == S_BWAIT0 || state == S_BWAIT1) && !enter) |=> $stable(state));

  p_open_after_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    (state != S_CMP2) |=> !$rose(unlock));

  p_alarm_after_cmp_r4: assert property (@(posedge clk) disable iff (rst)
    (state != S_CMP2 && state != S_BCMP2) |=> !$rose(error));

endmodule

// File: tb/serial_combo_lock_tb.sv
module serial_combo_lock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter = 1'b0;
  logic       key_bit = 1'b0;
  logic [2:0] code = 3'b000;
  logic       unlock, error;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  serial_combo_lock u_dut (
    .clk(clk), .rst(rst), .enter(enter), .key_bit(key_bit),
    .code(code), .unlock(unlock), .error(error)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] c);
    @(negedge clk);
    rst = 1'b1; enter = 1'b0; code = c;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // enter pulse carries 'decoy' on key_bit, next cycle carries real bit
  task automatic enter_bit(input logic b, input logic decoy);
    @(negedge clk);
    enter = 1'b1; key_bit = decoy;
    @(posedge clk);
    @(negedge clk);
    enter = 1'b0; key_bit = b;
    @(posedge clk);
    @(negedge clk);
    key_bit = ~b;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      key_bit = ~key_bit;
    end
  endtask

  task automatic t_reset_state;
    do_reset(3'b101);
    check("R1 unlock after reset", unlock, 1'b0);
    check("R1 error after reset", error, 1'b0);
  endtask

  task automatic t_exhaustive;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [2:0] cc = 3'(c);
        logic [2:0] kk = 3'(k);
        do_reset(cc);
        enter_bit(kk[0], ~kk[0]);
        check("R4 no early error after entry 1", error, 1'b0);
        enter_bit(kk[1], ~kk[1]);
        check("R4 no early error after entry 2", error, 1'b0);
        check("R3 no early unlock", unlock, 1'b0);
        enter_bit(kk[2], ~kk[2]);
        check(kk == cc ? "R3 R8 unlock on match" : "R4 R8 unlock on mismatch",
              unlock, kk == cc);
        check(kk == cc ? "R3 R9 error on match" : "R4 R9 error on mismatch",
              error, kk != cc);
      end
    end
  endtask

  task automatic t_wait_hold;
    do_reset(3'b110);
    idle_cycles(15);
    enter_bit(1'b0, 1'b1);
    idle_cycles(20);
    enter_bit(1'b1, 1'b0);
    idle_cycles(20);
    check("R5 no outcome while waiting", unlock | error, 1'b0);
    enter_bit(1'b1, 1'b0);
    check("R5 unlock after long waits", unlock, 1'b1);
    do_reset(3'b110);
    enter_bit(1'b1, 1'b0);
    idle_cycles(20);
    enter_bit(1'b1, 1'b0);
    idle_cycles(20);
    check("R5 error track waits silently", error, 1'b0);
    enter_bit(1'b1, 1'b0);
    check("R5 error after long waits", error, 1'b1);
  endtask

  task automatic t_outcome_hold;
    do_reset(3'b011);
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b0, 1'b1);
    enter_bit(1'b1, 1'b1);
    enter_bit(1'b0, 1'b0);
    idle_cycles(5);
    check("R6 unlock held", unlock, 1'b1);
    check("R6 no error while open", error, 1'b0);
    do_reset(3'b011);
    check("R1 reset from open", unlock, 1'b0);
    enter_bit(1'b0, 1'b0);
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b0, 1'b0);
    enter_bit(1'b1, 1'b1);
    enter_bit(1'b1, 1'b1);
    check("R6 error held", error, 1'b1);
    check("R6 no unlock while alarmed", unlock, 1'b0);
    do_reset(3'b011);
    check("R1 reset from alarm", error, 1'b0);
  endtask

  task automatic t_code_change;
    do_reset(3'b011);
    @(negedge clk);
    code = 3'b100;
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b0, 1'b1);
    check("R7 stored code unlocks", unlock, 1'b1);
    do_reset(3'b011);
    code = 3'b100;
    enter_bit(1'b0, 1'b1);
    enter_bit(1'b0, 1'b1);
    enter_bit(1'b1, 1'b0);
    check("R7 new code ignored", error, 1'b1);
  endtask

  task automatic t_mid_reset;
    do_reset(3'b010);
    enter_bit(1'b0, 1'b0);
    enter_bit(1'b1, 1'b0);
    do_reset(3'b010);
    enter_bit(1'b0, 1'b1);
    enter_bit(1'b1, 1'b0);
    enter_bit(1'b0, 1'b1);
    check("R1 R2 sequence restarts after reset", unlock, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_exhaustive();
    t_wait_hold();
    t_outcome_hold();
    t_code_change();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule